// File: doc/BRIEF.md
# Chopper Polarity Control Sequencer

This block drives the chop polarity line of an offset-cancelling reference amplifier in a multiplexed sampling front end. When the line is high the amplifier inputs are swapped (reversed). When it is low they are connected straight through (positive). A two-bit mode register picks the behaviour. In automatic mode the polarity swaps at every multiplexer-cycle boundary, so the amplifier offset averages out. In the two fixed modes the line is held at one polarity.

The front end sends two single-clock pulses. One marks the end of each multiplexer cycle and the other marks the end of each accumulation interval. The block counts the completed cycles of each polarity within an interval. When an interval closes, it raises a one-clock flag if the two counts differ, because an unequal split leaves residual offset in that interval's result. Mode writes are staged and applied only at the next cycle boundary, so a cycle never changes polarity part-way through.

Top module: `chop_seq_top`

## Requirements
- R1: While `rstN` is low, and after it is released, `chopOut` is 0 (positive), `imbalance` is 0, and the staged mode is 00 (automatic), so the first `cycleEnd` with no write drives `chopOut` to 1.
- R2: `chopOut` changes only on a clock where `cycleEnd` is high. On every other clock it keeps its value, whatever is written to the mode register.
- R3: With mode code 00 in force, each `cycleEnd` inverts `chopOut`, and the new value is visible from the following clock.
- R4: Mode code 11 behaves exactly as code 00: each `cycleEnd` inverts `chopOut`.
- R5: With mode code 01, each `cycleEnd` sets `chopOut` to 0.
- R6: With mode code 10, each `cycleEnd` sets `chopOut` to 1.
- R7: A mode write (`modeWrEn` high, code on `modeWrData`) takes effect at the next `cycleEnd`. If several writes come before that boundary, the last one wins. A write on the same clock as `cycleEnd` is applied at that boundary.
- R8: Entering automatic mode (00 or 11) from a fixed mode continues from the present polarity. The first boundary after the switch inverts the value that the fixed mode left on `chopOut`.
- R9: Each `cycleEnd` counts the completed cycle as positive or reversed, according to the `chopOut` value held during that cycle. On an `intervalEnd` clock, `imbalance` is high for exactly the next clock if the two counts differ, and low otherwise. Both counts then restart from zero.
- R10: When `cycleEnd` and `intervalEnd` are high on the same clock, the completing cycle is counted in the interval that is closing, before the balance test. The next interval starts with both counts at zero.
- R11: Asserting `rstN` in the middle of operation returns the mode to 00, `chopOut` to 0 and both counts to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrData | input | 2 | Mode code: 00/11 automatic, 01 fixed positive, 10 fixed reversed |
| cycleEnd | input | 1 | One-clock pulse at the end of each multiplexer cycle |
| intervalEnd | input | 1 | One-clock pulse at the end of each accumulation interval |
| chopOut | output | 1 | Chop polarity; 1 = amplifier inputs reversed, 0 = positive |
| imbalance | output | 1 | One-clock flag after an interval whose positive and reversed cycle counts differ |

## Verification
A multiplexer-cycle boundary and an accumulation-interval close can land on the same clock. The completing cycle then has to be counted before the balance test, and the counts have to restart from zero afterwards. This overlap is forced by directed cases that close an interval right on an even and on an odd cycle count. It also occurs often in the seeded random run, where the two pulses are drawn independently. It is judged from the `imbalance` value one clock later, compared with a bench model whose counts already include the finishing cycle. A follow-up interval close then shows whether the counts really restarted from zero.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;

  // Mode codes; the two automatic encodings are deliberately equivalent.
  typedef enum logic [1:0] {
    MODE_AUTO_LO = 2'b00,
    MODE_POS     = 2'b01,
    MODE_REV     = 2'b10,
    MODE_AUTO_HI = 2'b11
  } chopMode_e;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic flip;       // invert polarity at this boundary
    logic forcePos;   // drive polarity low at this boundary
    logic forceRev;   // drive polarity high at this boundary
    logic tally;      // count the cycle that is completing
    logic closeIntv;  // run balance test and restart counts
  } chopStrobe_t;

  localparam int unsigned POL_NUM = 2;  // positive, reversed

  function automatic logic isAutoMode(chopMode_e m);
    return (m == MODE_AUTO_LO) || (m == MODE_AUTO_HI);
  endfunction

endpackage

// File: rtl/chop_seq_ctrl.sv
module chop_seq_ctrl
  import chop_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  input  logic        cycleEnd,
  input  logic        intervalEnd,
  output chopStrobe_t strobe,
  output chopMode_e   modeNext
);

  chopMode_e pendMode;

  // Latest written code, including a write on this very clock.
  always_comb begin
    if (modeWrEn) modeNext = chopMode_e'(modeWrData);
    else          modeNext = pendMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendMode <= MODE_AUTO_LO;
    else       pendMode <= modeNext;
  end

  // Decode only at cycle boundaries, so polarity never moves mid-cycle.
  always_comb begin
    strobe           = '0;
    strobe.tally     = cycleEnd;
    strobe.closeIntv = intervalEnd;
    if (cycleEnd) begin
      strobe.flip     = isAutoMode(modeNext);
      strobe.forcePos = (modeNext == MODE_POS);
      strobe.forceRev = (modeNext == MODE_REV);
    end
  end

endmodule

// File: rtl/chop_seq_dp.sv
module chop_seq_dp
  import chop_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  chopStrobe_t strobe,
  output logic        chopOut,
  output logic        imbalance
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                  chopQ;
  logic                  imbQ;
  logic [CNT_W-1:0]      cntQ   [POL_NUM];
  logic [CNT_W-1:0]      cntSum [POL_NUM];
  logic [POL_NUM-1:0]    polHit;

  // Index 0 counts positive cycles, index 1 reversed cycles.
  assign polHit[0] = strobe.tally & ~chopQ;
  assign polHit[1] = strobe.tally &  chopQ;

  for (genvar g = 0; g < POL_NUM; g++) begin : gPolCnt
    // Saturating add keeps a runaway interval from aliasing to balanced.
    always_comb begin
      if (polHit[g] && (cntQ[g] != CNT_MAX)) cntSum[g] = cntQ[g] + CNT_W'(1);
      else                                   cntSum[g] = cntQ[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                 cntQ[g] <= '0;
      else if (strobe.closeIntv) cntQ[g] <= '0;
      else                       cntQ[g] <= cntSum[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                chopQ <= 1'b0;
    else if (strobe.flip)     chopQ <= ~chopQ;
    else if (strobe.forcePos) chopQ <= 1'b0;
    else if (strobe.forceRev) chopQ <= 1'b1;
  end

  // Test uses post-tally sums, so a coincident boundary lands in this interval.
  always_ff @(posedge clk) begin
    if (!rstN) imbQ <= 1'b0;
    else       imbQ <= strobe.closeIntv && (cntSum[0] != cntSum[1]);
  end

  assign chopOut   = chopQ;
  assign imbalance = imbQ;

endmodule

// File: rtl/chop_seq_top.sv
module chop_seq_top
  import chop_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  input  logic       cycleEnd,
  input  logic       intervalEnd,
  output logic       chopOut,
  output logic       imbalance
);

  chopStrobe_t strobe;
  chopMode_e   modeNextE;
  logic [1:0]  modeNextW;

  assign modeNextW = modeNextE;

  chop_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeWrEn    (modeWrEn),
    .modeWrData  (modeWrData),
    .cycleEnd    (cycleEnd),
    .intervalEnd (intervalEnd),
    .strobe      (strobe),
    .modeNext    (modeNextE)
  );

  chop_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .chopOut   (chopOut),
    .imbalance (imbalance)
  );

endmodule

// File: rtl/chop_seq_chk.sv
module chop_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cycleEnd,
  input logic       intervalEnd,
  input logic       chopOut,
  input logic       imbalance,
  input logic [1:0] modeNext
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!chopOut && !imbalance));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEnd |=> $stable(chopOut));

  // R3
  auto_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && (modeNext == 2'b00 || modeNext == 2'b11)) |=> (chopOut != $past(chopOut)));

  // R5
  fixed_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && modeNext == 2'b01) |=> !chopOut);

  // R6
  fixed_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEnd && modeNext == 2'b10) |=> chopOut);

  // R9
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intervalEnd |=> !imbalance);

endmodule

bind chop_seq_top chop_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cycleEnd    (cycleEnd),
  .intervalEnd (intervalEnd),
  .chopOut     (chopOut),
  .imbalance   (imbalance),
  .modeNext    (modeNextW)
);

// File: tb/chop_seq_top_bench.sv
`timescale 1ns/1ps
module chop_seq_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [1:0] modeWrData = 2'b00;
  logic       cycleEnd = 1'b0;
  logic       intervalEnd = 1'b0;
  logic       chopOut;
  logic       imbalance;

  int checks = 0;
  int failures = 0;

  // model state
  logic [1:0] mPend;
  logic       mChop;
  logic       mImb;
  int         mPos;
  int         mRev;

  always #4 clk = ~clk;

  chop_seq_top u_chop_seq_top (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .cycleEnd(cycleEnd), .intervalEnd(intervalEnd),
    .chopOut(chopOut), .imbalance(imbalance)
  );

  function automatic logic nextChop(logic [1:0] m, logic cur);
    if (m == 2'b01) return 1'b0;
    if (m == 2'b10) return 1'b1;
    return ~cur;
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPend = 2'b00; mChop = 1'b0; mImb = 1'b0; mPos = 0; mRev = 0;
  endtask

  // Called at a negedge: drive, advance model over the next posedge, check at next negedge.
  task automatic step(logic we, logic [1:0] wd, logic ce, logic ie, string tag);
    logic [1:0] pn;
    modeWrEn = we; modeWrData = wd; cycleEnd = ce; intervalEnd = ie;
    pn = we ? wd : mPend;
    if (ce) begin
      if (mChop) mRev++; else mPos++;
    end
    mImb = ie && (mPos != mRev);
    if (ie) begin mPos = 0; mRev = 0; end
    if (ce) mChop = nextChop(pn, mChop);
    mPend = pn;
    @(negedge clk);
    check(tag, chopOut, mChop, "chopOut");
    check(tag, imbalance, mImb, "imbalance");
  endtask

  task automatic doReset(string tag);
    rstN = 1'b0;
    modeWrEn = 0; cycleEnd = 0; intervalEnd = 0; modeWrData = 2'b00;
    repeat (2) @(negedge clk);
    modelReset();
    check(tag, chopOut, 1'b0, "chopOut in reset");
    check(tag, imbalance, 1'b0, "imbalance in reset");
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20061));
    modelReset();
    @(negedge clk);
    doReset("R1");
    // R2: idle clocks, then writes without boundary, polarity must not move
    step(0, 2'b00, 0, 0, "R2");
    step(0, 2'b00, 0, 0, "R2");
    // R1 / R3: default mode is automatic
    step(0, 2'b00, 1, 0, "R1");
    step(0, 2'b00, 1, 0, "R3");
    step(0, 2'b00, 1, 0, "R3");
    // R4: code 11, write alone has no effect until boundary
    step(1, 2'b11, 0, 0, "R7");
    step(0, 2'b00, 1, 0, "R4");
    step(0, 2'b00, 1, 0, "R4");
    // R7: last write wins; R6
    step(1, 2'b01, 0, 0, "R2");
    step(1, 2'b10, 0, 0, "R7");
    step(0, 2'b00, 1, 0, "R6");
    step(0, 2'b00, 1, 0, "R6");
    // R5 / R7: write on same clock as boundary
    step(1, 2'b01, 1, 0, "R5");
    step(0, 2'b00, 1, 0, "R5");
    // R8: from fixed low into automatic -> high
    step(1, 2'b00, 0, 0, "R2");
    step(0, 2'b00, 1, 0, "R8");
    // R8: from fixed high into code 11 -> low
    step(1, 2'b10, 1, 0, "R6");
    step(1, 2'b11, 1, 0, "R8");
    // R9: start clean interval
    step(0, 2'b00, 0, 1, "R9");
    step(0, 2'b00, 1, 0, "R9");
    step(0, 2'b00, 1, 0, "R9");
    step(0, 2'b00, 0, 1, "R9");   // balanced -> flag low
    step(0, 2'b00, 1, 0, "R9");
    step(0, 2'b00, 1, 0, "R9");
    step(0, 2'b00, 1, 0, "R9");
    step(0, 2'b00, 0, 1, "R9");   // odd -> flag high
    step(0, 2'b00, 0, 0, "R9");   // flag lasts one clock
    // R10: coincident boundary and close
    step(0, 2'b00, 1, 0, "R10");
    step(0, 2'b00, 1, 1, "R10");  // two cycles incl. coincident -> balanced
    step(0, 2'b00, 0, 1, "R10");  // counts restarted -> balanced
    step(0, 2'b00, 1, 1, "R10");  // single coincident cycle -> imbalanced
    step(0, 2'b00, 0, 0, "R10");
    // R9: fixed mode makes every cycle one polarity
    step(1, 2'b10, 1, 0, "R6");
    step(0, 2'b00, 1, 0, "R6");
    step(0, 2'b00, 0, 1, "R9");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we, ce, ie;
      logic [1:0] wd;
      we = ($urandom % 6) == 0;
      wd = 2'($urandom);
      ce = ($urandom % 2) == 0;
      ie = ($urandom % 7) == 0;
      step(we, wd, ce, ie, "R3 R9 R10 random");
    end
    // R11: reset mid-run
    step(1, 2'b10, 1, 0, "R6");
    step(0, 2'b00, 1, 0, "R6");
    doReset("R11");
    step(0, 2'b00, 1, 0, "R11");  // mode back to automatic -> high
    step(0, 2'b00, 0, 1, "R11");  // one positive cycle only -> flag
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule